// File: doc/BRIEF.md
# Programmable Interval Timer Counter Channel

This block is one counter channel of a three-channel interval timer. It counts cycles in which a tick enable input is high and drives an output line whose waveform depends on the selected operating mode. Modes cover a one-shot that goes high at terminal count, a retriggerable one-shot, a rate generator that dips low for a single tick each period, a square wave, and software- and gate-triggered strobes. A rising edge on the gate input restarts counting in the retriggerable modes.

Software programs the channel through a byte-wide port. A control-word write (with the control select strobe high) picks the mode, the BCD flag and how count bytes are sequenced. Data writes then supply the initial count, low byte, high byte, or low then high. Data reads return the running count in the same byte order. A latch command freezes a snapshot of the count so that two byte reads stay consistent while counting goes on.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel is in mode 3 (square wave) with a count of 65536, access set to low-byte-only, out_o high, and the count read back as 65536 minus the ticks seen since reset (low 16 bits).
- R2: A control word is accepted only when its bits 7:6 equal the channel index parameter; otherwise it changes nothing. Bits 5:4 select access (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 the mode, where 6 and 7 act as 2 and 3, and bit 0 sets the BCD flag, which is shown on bcd_o and does not change counting.
- R3: A count load takes effect on the data write that completes it: low-only loads the byte with high byte zero, high-only loads the byte shifted up eight bits, low-then-high loads on the second byte only. A completed value of 0 means 65536. Every load restarts the elapsed-tick reference at zero.
- R4: In modes 0 and 1, out_o is low while elapsed ticks are below the count and high from the tick the count is reached, staying high until a reload or restart.
- R5: In mode 2, out_o is high except for exactly one tick each time elapsed ticks reach a nonzero multiple of the count.
- R6: In mode 3 with count N, out_o is high for the first (N+1)>>1 ticks of each period and low for the remainder, repeating every N ticks.
- R7: In modes 4 and 5, out_o is high except during the single tick at which elapsed ticks equal the count.
- R8: A rising edge on gate_i restarts counting from zero elapsed ticks in modes 1, 2, 3 and 5, and has no effect in modes 0 and 4.
- R9: A data read returns the current count (count minus elapsed ticks in modes 0, 1, 4, 5; count minus period phase in modes 2, 3; low 16 bits) one cycle later: low byte in low-only access, high byte in high-only access, and alternately low then high in low-then-high access, where one byte toggle is shared by reads and writes.
- R10: A control word with access field 0 latches the current count without changing mode or access; following reads return the latched bytes in the access order, after which reads return the live count. A latch command while a latch is held is ignored.
- R11: Elapsed ticks and period phase advance only in cycles with tick_i high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| gate_i | input | 1 | Gate; rising edge retriggers in modes 1, 2, 3, 5 |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe for count bytes |
| ctrl_sel_i | input | 1 | High selects the control word for wr_i, low selects count data |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid the cycle after rd_i |
| out_o | output | 1 | Channel output waveform |
| bcd_o | output | 1 | Stored BCD flag |

## Verification
The bench probes the tick where each waveform flips: the exact terminal tick in the one-shot modes, the single low tick of the rate generator and strobes, and the unequal halves of an odd square-wave count; a design off by one tick would show out_o changing one step early or late. It loads a zero count and runs the full 65536 ticks, which a design treating zero literally would end at once. Gate edges are applied in retriggering and non-retriggering modes, so a design that restarts in the wrong modes, or never, shows the wrong level afterward. Latched reads are interleaved with further counting and a second latch, so a design that tracks the live count or re-latches returns different bytes.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    RW_LO = 2'd0,
    RW_HI = 2'd1,
    RW_W0 = 2'd2,
    RW_W1 = 2'd3
  } rw_st_e;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;
endpackage

// File: rtl/pit_ctrl_if.sv
module pit_ctrl_if
  import pit_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int CHAN_IDX = 0,
  localparam int CNT_W   = 2 * BYTE_W,
  localparam int VAL_W   = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              ctrl_sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cur_val_i,
  output mode_e             mode_o,
  output logic              bcd_o,
  output logic [VAL_W-1:0]  reload_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam logic [VAL_W-1:0] FULL_CNT = VAL_W'(1) << CNT_W;

  rw_st_e             rw_q, latch_st_q;
  logic               latched_q;
  logic [CNT_W-1:0]   latch_val_q;
  logic [BYTE_W-1:0]  lo_buf_q;

  logic       ctrl_hit, data_wr, data_rd;
  logic [1:0] acc;
  logic [2:0] m_raw, m_norm;
  logic [CNT_W-1:0] new_cnt;
  logic [VAL_W-1:0] new_val;

  assign ctrl_hit = wr_i & ctrl_sel_i & (wdata_i[BYTE_W-1 -: 2] == 2'(CHAN_IDX));
  assign acc      = wdata_i[BYTE_W-3 -: 2];
  assign data_wr  = wr_i & ~ctrl_sel_i;
  assign data_rd  = rd_i & ~ctrl_sel_i;
  assign m_raw    = wdata_i[3:1];
  // modes 6 and 7 fold onto 2 and 3
  assign m_norm   = m_raw[1] ? {1'b0, m_raw[1:0]} : m_raw;

  always_comb begin
    unique case (rw_q)
      RW_LO:   new_cnt = {{BYTE_W{1'b0}}, wdata_i};
      RW_HI:   new_cnt = {wdata_i, {BYTE_W{1'b0}}};
      RW_W1:   new_cnt = {wdata_i, lo_buf_q};
      default: new_cnt = '0;
    endcase
    new_val = (new_cnt == '0) ? FULL_CNT : {1'b0, new_cnt};
  end

  assign load_o = data_wr & (rw_q != RW_W0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= M_SQUARE;
      bcd_o       <= 1'b0;
      rw_q        <= RW_LO;
      reload_o    <= FULL_CNT;
      lo_buf_q    <= '0;
      latched_q   <= 1'b0;
      latch_st_q  <= RW_LO;
      latch_val_q <= '0;
      rdata_o     <= '0;
    end else begin
      if (ctrl_hit) begin
        if (acc == 2'd0) begin
          if (!latched_q) begin
            latched_q   <= 1'b1;
            latch_st_q  <= rw_q;
            latch_val_q <= cur_val_i;
          end
        end else begin
          mode_o <= mode_e'(m_norm);
          bcd_o  <= wdata_i[0];
          rw_q   <= rw_st_e'(acc - 2'd1);
        end
      end
      if (data_wr) begin
        unique case (rw_q)
          RW_W0: begin
            lo_buf_q <= wdata_i;
            rw_q     <= RW_W1;
          end
          RW_W1: begin
            reload_o <= new_val;
            rw_q     <= RW_W0;
          end
          default: reload_o <= new_val;
        endcase
      end
      if (data_rd) begin
        if (latched_q) begin
          unique case (latch_st_q)
            RW_LO: begin
              rdata_o   <= latch_val_q[BYTE_W-1:0];
              latched_q <= 1'b0;
            end
            RW_HI: begin
              rdata_o   <= latch_val_q[CNT_W-1:BYTE_W];
              latched_q <= 1'b0;
            end
            RW_W0: begin
              rdata_o    <= latch_val_q[BYTE_W-1:0];
              latch_st_q <= RW_W1;
            end
            default: begin
              rdata_o   <= latch_val_q[CNT_W-1:BYTE_W];
              latched_q <= 1'b0;
            end
          endcase
        end else begin
          unique case (rw_q)
            RW_LO: rdata_o <= cur_val_i[BYTE_W-1:0];
            RW_HI: rdata_o <= cur_val_i[CNT_W-1:BYTE_W];
            RW_W0: begin
              rdata_o <= cur_val_i[BYTE_W-1:0];
              rw_q    <= RW_W1;
            end
            default: begin
              rdata_o <= cur_val_i[CNT_W-1:BYTE_W];
              rw_q    <= RW_W0;
            end
          endcase
        end
      end
    end
  end

  assert_zero_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && rw_q == RW_LO && wdata_i == '0) |=> reload_o == FULL_CNT);

  assert_word_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !latched_q && !data_wr && rw_q == RW_W0) |=> rw_q == RW_W1);

  assert_latch_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_q && !data_rd) |=> (latched_q && $stable(latch_val_q)));
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit GATE_RST = 1'b1,
  localparam int VAL_W   = CNT_W + 1,
  localparam int EL_W    = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  mode_e            mode_i,
  input  logic [VAL_W-1:0] reload_i,
  output logic [EL_W-1:0]  elapsed_o,
  output logic [VAL_W-1:0] phase_o,
  output logic [CNT_W-1:0] cur_val_o
);
  logic gate_q, retrig_mode, gate_rise, restart, periodic;

  assign retrig_mode = mode_i inside {M_ONESHOT, M_RATE, M_SQUARE, M_HWSTB};
  assign periodic    = mode_i inside {M_RATE, M_SQUARE};
  assign gate_rise   = gate_i & ~gate_q;
  assign restart     = load_i | (gate_rise & retrig_mode);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q    <= GATE_RST;
      elapsed_o <= '0;
      phase_o   <= '0;
    end else begin
      gate_q <= gate_i;
      if (restart) begin
        elapsed_o <= '0;
        phase_o   <= '0;
      end else if (tick_i) begin
        if (!(&elapsed_o)) elapsed_o <= elapsed_o + EL_W'(1);
        phase_o <= (phase_o >= reload_i - VAL_W'(1)) ? '0 : phase_o + VAL_W'(1);
      end
    end
  end

  assign cur_val_o = periodic ? CNT_W'(reload_i - phase_o)
                              : CNT_W'(EL_W'(reload_i) - elapsed_o);

  assert_restart_on_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (elapsed_o == '0 && phase_o == '0));

  assert_gate_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !gate_q && retrig_mode) |=> elapsed_o == '0);

  assert_phase_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < reload_i);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart) |=> ($stable(elapsed_o) && $stable(phase_o)));
endmodule

// File: rtl/pit_out_gen.sv
module pit_out_gen
  import pit_pkg::*;
#(
  parameter int CNT_W   = 16,
  localparam int VAL_W  = CNT_W + 1,
  localparam int EL_W   = CNT_W + 2
) (
  input  mode_e            mode_i,
  input  logic [VAL_W-1:0] reload_i,
  input  logic [EL_W-1:0]  elapsed_i,
  input  logic [VAL_W-1:0] phase_i,
  output logic             out_o
);
  logic [EL_W-1:0]  reload_ext;
  logic [VAL_W-1:0] half;

  assign reload_ext = EL_W'(reload_i);
  assign half       = VAL_W'((EL_W'(reload_i) + EL_W'(1)) >> 1);

  always_comb begin
    unique case (mode_i)
      M_TERM, M_ONESHOT: out_o = (elapsed_i >= reload_ext);
      M_RATE:            out_o = !((phase_i == '0) && (elapsed_i != '0));
      M_SQUARE:          out_o = (phase_i < half);
      default:           out_o = (elapsed_i != reload_ext);
    endcase
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              ctrl_sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o,
  output logic              bcd_o
);
  localparam int CNT_W    = 2 * BYTE_W;
  localparam int VAL_W    = CNT_W + 1;
  localparam int EL_W     = CNT_W + 2;
  localparam bit GATE_RST = (CHAN_IDX != 2);

  mode_e            mode;
  logic [VAL_W-1:0] reload;
  logic             load;
  logic [CNT_W-1:0] cur_val;
  logic [EL_W-1:0]  elapsed;
  logic [VAL_W-1:0] phase;

  pit_ctrl_if #(.BYTE_W(BYTE_W), .CHAN_IDX(CHAN_IDX)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .rd_i, .ctrl_sel_i, .wdata_i,
    .cur_val_i(cur_val),
    .mode_o(mode),
    .bcd_o,
    .reload_o(reload),
    .load_o(load),
    .rdata_o
  );

  pit_count_core #(.CNT_W(CNT_W), .GATE_RST(GATE_RST)) u_core (
    .clk_i, .rst_ni, .tick_i, .gate_i,
    .load_i(load),
    .mode_i(mode),
    .reload_i(reload),
    .elapsed_o(elapsed),
    .phase_o(phase),
    .cur_val_o(cur_val)
  );

  pit_out_gen #(.CNT_W(CNT_W)) u_out (
    .mode_i(mode),
    .reload_i(reload),
    .elapsed_i(elapsed),
    .phase_i(phase),
    .out_o
  );
endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       gate_i = 1'b1;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       ctrl_sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       out_o;
  logic       bcd_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  pit_channel u0 (.*);

  // {mode, count, ticks after load, expected out}
  localparam int NV = 28;
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 16'd5, 8'd0, 1'b0}, {3'd0, 16'd5, 8'd4, 1'b0},
    {3'd0, 16'd5, 8'd5, 1'b1}, {3'd0, 16'd5, 8'd9, 1'b1},
    {3'd1, 16'd2, 8'd1, 1'b0}, {3'd1, 16'd2, 8'd2, 1'b1},
    {3'd2, 16'd4, 8'd0, 1'b1}, {3'd2, 16'd4, 8'd3, 1'b1},
    {3'd2, 16'd4, 8'd4, 1'b0}, {3'd2, 16'd4, 8'd5, 1'b1},
    {3'd2, 16'd4, 8'd8, 1'b0},
    {3'd3, 16'd5, 8'd2, 1'b1}, {3'd3, 16'd5, 8'd3, 1'b0},
    {3'd3, 16'd5, 8'd4, 1'b0}, {3'd3, 16'd5, 8'd5, 1'b1},
    {3'd3, 16'd4, 8'd1, 1'b1}, {3'd3, 16'd4, 8'd2, 1'b0},
    {3'd3, 16'd4, 8'd4, 1'b1},
    {3'd4, 16'd3, 8'd2, 1'b1}, {3'd4, 16'd3, 8'd3, 1'b0},
    {3'd4, 16'd3, 8'd4, 1'b1}, {3'd4, 16'd3, 8'd10, 1'b1},
    {3'd5, 16'd2, 8'd2, 1'b0}, {3'd5, 16'd2, 8'd3, 1'b1},
    {3'd6, 16'd3, 8'd3, 1'b0}, {3'd6, 16'd3, 8'd4, 1'b1},
    {3'd7, 16'd2, 8'd1, 1'b0}, {3'd7, 16'd2, 8'd2, 1'b1}
  };

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd0, 3'd1: return "R4";
      3'd2:       return "R5";
      3'd3:       return "R6";
      3'd4, 3'd5: return "R7";
      default:    return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [7:0] b);
    @(negedge clk_i); wr_i = 1'b1; ctrl_sel_i = 1'b1; wdata_i = b;
    @(negedge clk_i); wr_i = 1'b0; ctrl_sel_i = 1'b0;
  endtask

  task automatic wr_data(logic [7:0] b);
    @(negedge clk_i); wr_i = 1'b1; wdata_i = b;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] exp);
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    chk(req, 32'(rdata_o), 32'(exp));
  endtask

  task automatic adv(int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic gate_pulse();
    @(negedge clk_i); gate_i = 1'b0;
    @(negedge clk_i); gate_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk("R1 out", 32'(out_o), 32'd1);
    rd_chk("R1 count", 8'h00);
    adv(257);
    rd_chk("R1 lsb-only", 8'hFF);
    rd_chk("R1 lsb-only", 8'hFF);
    chk("R1 out", 32'(out_o), 32'd1);

    foreach (VEC[i]) begin
      logic [2:0]  m;
      logic [15:0] n;
      logic [7:0]  t;
      logic        e;
      {m, n, t, e} = VEC[i];
      wr_ctrl({2'b00, 2'b11, m, 1'b0});
      wr_data(n[7:0]);
      wr_data(n[15:8]);
      adv(int'(t));
      chk(req_of(m), 32'(out_o), 32'(e));
    end

    // R2: foreign channel select ignored, BCD stored only
    wr_ctrl(8'h30); wr_data(8'd10); wr_data(8'd0);
    chk("R4", 32'(out_o), 32'd0);
    wr_ctrl(8'h78);
    chk("R2 select", 32'(out_o), 32'd0);
    adv(10);
    chk("R2 select", 32'(out_o), 32'd1);
    wr_ctrl(8'h35);
    chk("R2 bcd", 32'(bcd_o), 32'd1);
    wr_data(8'd3); wr_data(8'd0);
    adv(3);
    chk("R2 bcd", 32'(out_o), 32'd0);
    adv(1);
    chk("R2 bcd", 32'(out_o), 32'd1);

    // R3: high-only load, zero count, reload restart, partial word
    wr_ctrl(8'h20); wr_data(8'h01);
    adv(255);
    chk("R3 msb", 32'(out_o), 32'd0);
    adv(1);
    chk("R3 msb", 32'(out_o), 32'd1);
    wr_ctrl(8'h30); wr_data(8'h00); wr_data(8'h00);
    adv(65535);
    chk("R3 zero", 32'(out_o), 32'd0);
    adv(1);
    chk("R3 zero", 32'(out_o), 32'd1);
    wr_ctrl(8'h30); wr_data(8'd5); wr_data(8'd0);
    adv(3);
    wr_data(8'd5); wr_data(8'd0);
    adv(3);
    chk("R3 restart", 32'(out_o), 32'd0);
    adv(2);
    chk("R3 restart", 32'(out_o), 32'd1);
    wr_data(8'd2);
    chk("R3 partial", 32'(out_o), 32'd1);
    wr_data(8'd0);
    chk("R3 complete", 32'(out_o), 32'd0);

    // R8: gate retrigger per mode
    wr_ctrl(8'h32); wr_data(8'd4); wr_data(8'd0);
    adv(4);
    chk("R8 m1", 32'(out_o), 32'd1);
    gate_pulse();
    chk("R8 m1", 32'(out_o), 32'd0);
    adv(4);
    chk("R8 m1", 32'(out_o), 32'd1);
    wr_ctrl(8'h30); wr_data(8'd4); wr_data(8'd0);
    adv(2); gate_pulse(); adv(2);
    chk("R8 m0", 32'(out_o), 32'd1);
    wr_ctrl(8'h38); wr_data(8'd3); wr_data(8'd0);
    adv(2); gate_pulse(); adv(1);
    chk("R8 m4", 32'(out_o), 32'd0);
    wr_ctrl(8'h3A); wr_data(8'd3); wr_data(8'd0);
    adv(2); gate_pulse(); adv(1);
    chk("R8 m5", 32'(out_o), 32'd1);
    wr_ctrl(8'h36); wr_data(8'd4); wr_data(8'd0);
    adv(2);
    chk("R6", 32'(out_o), 32'd0);
    gate_pulse();
    chk("R8 m3", 32'(out_o), 32'd1);

    // R9: read byte order
    wr_ctrl(8'h34); wr_data(8'h34); wr_data(8'h12);
    adv(4);
    rd_chk("R9 word lo", 8'h30);
    rd_chk("R9 word hi", 8'h12);
    wr_ctrl(8'h30); wr_data(8'h00); wr_data(8'h01);
    adv(16);
    rd_chk("R9 oneshot lo", 8'hF0);
    rd_chk("R9 oneshot hi", 8'h00);
    wr_ctrl(8'h24); wr_data(8'h12);
    adv(1);
    rd_chk("R9 msb-only", 8'h11);
    rd_chk("R9 msb-only", 8'h11);

    // R10: latch
    wr_ctrl(8'h34); wr_data(8'h34); wr_data(8'h12);
    adv(4);
    wr_ctrl(8'h00);
    adv(5);
    rd_chk("R10 latched lo", 8'h30);
    rd_chk("R10 latched hi", 8'h12);
    rd_chk("R10 live lo", 8'h2B);
    rd_chk("R10 live hi", 8'h12);
    wr_ctrl(8'h00);
    adv(2);
    wr_ctrl(8'h00);
    adv(1);
    rd_chk("R10 first latch lo", 8'h2B);
    rd_chk("R10 first latch hi", 8'h12);
    rd_chk("R10 live lo", 8'h28);
    rd_chk("R10 live hi", 8'h12);
    chk("R10 mode kept", 32'(out_o), 32'd1);

    // R11: no tick, no progress
    wr_ctrl(8'h30); wr_data(8'd3); wr_data(8'd0);
    repeat (10) @(negedge clk_i);
    chk("R11 idle", 32'(out_o), 32'd0);
    adv(3);
    chk("R11 tick", 32'(out_o), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule